// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block sits after the clock dividers of a clock generator and decides, for two groups of gated outputs, whether each group runs or is parked. One group is driven from the internal processor clock and the other from the internal bus clock. Each group has an active-low stop request that may change at any time with respect to either clock. The block synchronizes that request in the group's own clock domain and then stops or restarts the group only while the source clock is low. A stopped group therefore always rests at 0, and the first high pulse after a restart is a complete one.

Stop requests are obeyed only when the configuration input selects the power-managed (mobile) mode. In the other mode both groups run regardless of the requests. A free-running copy of the bus clock is passed through without any gating. Each group drives a parameterized number of identical outputs.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, every gated output is 0. After release, each group starts at the first falling edge of its clock, so the first output pulse is a full one.
- R2: Each stop request passes through a chain of `SYNC_STAGES` flip-flops (default 2) clocked by its own group's clock before it can affect that group.
- R3: A stopped gated output is held at logic 0 for the whole time it is stopped.
- R4: A group's enable changes only while that group's clock is low. Every high pulse on a gated output is therefore exactly as wide as the high phase of the source clock.
- R5: In mobile mode, when `cpu_stop_n` is sampled low at processor rising edge n, the processor outputs still pulse at edge n+1 and give no pulse from edge n+2 onward. This is fewer than 4 processor clocks.
- R6: In mobile mode, when `cpu_stop_n` is sampled high at processor rising edge n, the processor outputs pulse at edge n+2.
- R7: In mobile mode, when `pci_stop_n` is sampled low at bus rising edge n, the synchronized request changes at edge n+1 and the bus outputs give no pulse from edge n+2 onward. This is one bus clock after the synchronized edge.
- R8: In mobile mode, when `pci_stop_n` is sampled high at bus rising edge n, the bus outputs pulse on edge n+2. This is the first rising edge after the synchronized release.
- R9: When `mobile_mode` is 0, both stop inputs are ignored and both groups run continuously.
- R10: `pci_free_o` always follows `pci_clk`, whatever the stop inputs are.
- R11: Stopping one group has no effect on the other group's outputs.
- R12: All outputs of one group carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal processor clock, source of the processor group |
| pci_clk | input | 1 | Internal bus clock, source of the bus group and the free output |
| rst_n | input | 1 | Asynchronous active-low reset |
| mobile_mode | input | 1 | 1 = stop requests obeyed, 0 = stop requests ignored |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the processor group |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for the bus group |
| cpu_clk_o | output | CPU_FANOUT | Gated processor clock outputs |
| pci_clk_o | output | PCI_FANOUT | Gated bus clock outputs |
| pci_free_o | output | 1 | Ungated bus clock output |

## Verification
On every edge, the assertions relate each stop input to the group enable two cycles later, in both directions and in both modes. They also check at every enable change that the enable moved only while its clock was low. Only the bench's scenarios show the waveforms at the ports. Those scenarios cover full-width pulses at restart, parking at 0, identical fan-out copies, the free bus clock being untouched, and the independence of the two groups under overlapping random stop patterns, including requests shorter than one clock.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Default depth of the request synchronizers
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // A synchronized request stops a group only in the power-managed mode
  function automatic logic hold_request(input logic mobile_en,
                                        input logic stop_sync_n);
    return mobile_en & ~stop_sync_n;
  endfunction

  // Value the low-phase enable register loads
  function automatic logic next_enable(input logic mobile_en,
                                       input logic stop_sync_n);
    return ~hold_request(mobile_en, stop_sync_n);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
// Multi-flop synchronizer for an asynchronous level (R2)
module clkstop_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("clkstop_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/clkstop_cell.sv
// Low-phase enable register and AND gate: the enable moves only while clk is low (R3, R4)
module clkstop_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_d,
  output logic en_q,
  output logic clk_g
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;  // parked low during reset (R1)
    else        en_q <= en_d;
  end

  assign clk_g = clk & en_q;
endmodule

// File: rtl/clkstop_group.sv
// One gated clock group: synchronizer, enable decision, gate, fan-out
module clkstop_group
  import clkstop_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned FANOUT      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mobile_mode,
  input  logic              stop_n,
  output logic              run_en,
  output logic [FANOUT-1:0] clk_o
);
  logic stop_sync_n;
  logic en_next;
  logic clk_gated;

  clkstop_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (stop_n),
    .q    (stop_sync_n)
  );

  assign en_next = next_enable(mobile_mode, stop_sync_n);  // R9 when mobile_mode is 0

  clkstop_cell u_cell (
    .clk  (clk),
    .rst_n(rst_n),
    .en_d (en_next),
    .en_q (run_en),
    .clk_g(clk_gated)
  );

  // every copy is driven by the one gated net (R12)
  generate
    for (genvar i = 0; i < FANOUT; i++) begin : g_fan
      assign clk_o[i] = clk_gated;
    end
  endgenerate
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned CPU_FANOUT  = 4,
  parameter int unsigned PCI_FANOUT  = 6
) (
  input  logic                  cpu_clk,
  input  logic                  pci_clk,
  input  logic                  rst_n,
  input  logic                  mobile_mode,
  input  logic                  cpu_stop_n,
  input  logic                  pci_stop_n,
  output logic [CPU_FANOUT-1:0] cpu_clk_o,
  output logic [PCI_FANOUT-1:0] pci_clk_o,
  output logic                  pci_free_o
);
  // named enables, observed by the bound checker
  logic cpu_run_en;
  logic pci_run_en;

  clkstop_group #(
    .SYNC_STAGES(SYNC_STAGES),
    .FANOUT     (CPU_FANOUT)
  ) u_cpu_grp (
    .clk        (cpu_clk),
    .rst_n      (rst_n),
    .mobile_mode(mobile_mode),
    .stop_n     (cpu_stop_n),
    .run_en     (cpu_run_en),
    .clk_o      (cpu_clk_o)
  );

  clkstop_group #(
    .SYNC_STAGES(SYNC_STAGES),
    .FANOUT     (PCI_FANOUT)
  ) u_pci_grp (
    .clk        (pci_clk),
    .rst_n      (rst_n),
    .mobile_mode(mobile_mode),
    .stop_n     (pci_stop_n),
    .run_en     (pci_run_en),
    .clk_o      (pci_clk_o)
  );

  assign pci_free_o = pci_clk;  // R10: never gated
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk (
  input logic cpu_clk,
  input logic pci_clk,
  input logic rst_n,
  input logic mobile_mode,
  input logic cpu_stop_n,
  input logic pci_stop_n,
  input logic cpu_en,
  input logic pci_en
);
  AST_CPU_OFF_LATENCY: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (mobile_mode && !cpu_stop_n) |=> ##1 !cpu_en);  // R5

  AST_CPU_ON_LATENCY: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (!mobile_mode || cpu_stop_n) |=> ##1 cpu_en);  // R6

  AST_PCI_OFF_LATENCY: assert property (@(posedge pci_clk) disable iff (!rst_n)
    (mobile_mode && !pci_stop_n) |=> ##1 !pci_en);  // R7

  AST_PCI_ON_LATENCY: assert property (@(posedge pci_clk) disable iff (!rst_n)
    (!mobile_mode || pci_stop_n) |=> ##1 pci_en);  // R8

  always @(cpu_en) begin
    if (rst_n) AST_CPU_EN_LOW_PHASE: assert (cpu_clk == 1'b0);  // R4
  end

  always @(pci_en) begin
    if (rst_n) AST_PCI_EN_LOW_PHASE: assert (pci_clk == 1'b0);  // R4
  end
endmodule

bind clkstop_gate clkstop_gate_chk u_chk (
  .cpu_clk    (cpu_clk),
  .pci_clk    (pci_clk),
  .rst_n      (rst_n),
  .mobile_mode(mobile_mode),
  .cpu_stop_n (cpu_stop_n),
  .pci_stop_n (pci_stop_n),
  .cpu_en     (cpu_run_en),
  .pci_en     (pci_run_en)
);

// File: tb/clkstop_gate_tb.sv
module clkstop_gate_tb;
  localparam int CPU_N = 4;
  localparam int PCI_N = 6;

  logic cpu_clk = 1'b0;
  logic pci_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mobile_mode = 1'b1;
  logic cpu_stop_n = 1'b1;
  logic pci_stop_n = 1'b1;
  logic [CPU_N-1:0] cpu_clk_o;
  logic [PCI_N-1:0] pci_clk_o;
  logic pci_free_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 cpu_clk = ~cpu_clk;   // 125 MHz
  always #8 pci_clk = ~pci_clk;

  clkstop_gate #(.SYNC_STAGES(2), .CPU_FANOUT(CPU_N), .PCI_FANOUT(PCI_N)) u_dut (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n), .mobile_mode(mobile_mode),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pci_free_o(pci_free_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Output pulse at edge n follows the request sampled two edges earlier (R2)
  function automatic logic exp_run(input logic mobile, input logic stop_n_two_ago);
    if (!mobile) return 1'b1;
    return stop_n_two_ago;
  endfunction

  function automatic int all_bits(input int width, input logic v);
    return v ? ((1 << width) - 1) : 0;
  endfunction

  // processor group monitor: R5, R6, R9, R4, R12
  logic c_h1 = 1'b1, c_h2 = 1'b1;
  always @(posedge cpu_clk) begin
    logic e;
    if (!rst_n) begin
      c_h1 = 1'b1; c_h2 = 1'b1;
    end else begin
      e = exp_run(mobile_mode, c_h2);
      c_h2 = c_h1; c_h1 = cpu_stop_n;
      #1;
      chk(cpu_clk_o == all_bits(CPU_N, e),
          !mobile_mode ? "R9" : (e ? "R6" : "R5"), cpu_clk_o, all_bits(CPU_N, e));
      chk(pci_free_o == pci_clk, "R10", pci_free_o, pci_clk);
      #2;
      chk(cpu_clk_o == all_bits(CPU_N, e), "R4", cpu_clk_o, all_bits(CPU_N, e));
      chk(cpu_clk_o == 0 || &cpu_clk_o, "R12", cpu_clk_o, all_bits(CPU_N, e));
    end
  end

  always @(negedge cpu_clk) begin
    #1;
    if (rst_n) chk(cpu_clk_o == 0, "R3", cpu_clk_o, 0);
  end

  // bus group monitor: R7, R8, R9, R4, R12
  logic p_h1 = 1'b1, p_h2 = 1'b1;
  always @(posedge pci_clk) begin
    logic e;
    if (!rst_n) begin
      p_h1 = 1'b1; p_h2 = 1'b1;
    end else begin
      e = exp_run(mobile_mode, p_h2);
      p_h2 = p_h1; p_h1 = pci_stop_n;
      #1;
      chk(pci_clk_o == all_bits(PCI_N, e),
          !mobile_mode ? "R9" : (e ? "R8" : "R7"), pci_clk_o, all_bits(PCI_N, e));
      #5;
      chk(pci_clk_o == all_bits(PCI_N, e), "R4", pci_clk_o, all_bits(PCI_N, e));
      chk(pci_clk_o == 0 || &pci_clk_o, "R12", pci_clk_o, all_bits(PCI_N, e));
    end
  end

  always @(negedge pci_clk) begin
    #1;
    if (rst_n) begin
      chk(pci_clk_o == 0, "R3", pci_clk_o, 0);
      chk(pci_free_o == 1'b0, "R10", pci_free_o, 0);
    end
  end

  task automatic do_reset(input logic mode);
    rst_n = 1'b0;
    mobile_mode = mode;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    repeat (4) @(posedge cpu_clk);
    #1;
    chk(cpu_clk_o == 0 && pci_clk_o == 0, "R1", {cpu_clk_o, pci_clk_o}, 0);
    #1 rst_n = 1'b1;
    @(posedge cpu_clk); #2;
    chk(&cpu_clk_o, "R1", cpu_clk_o, all_bits(CPU_N, 1'b1));
  endtask

  // inputs change 2 ns after a processor falling edge, away from every clock edge
  task automatic wait_slot(input int n);
    repeat (n) @(negedge cpu_clk);
    #2;
  endtask

  task automatic random_run(input int cycles);
    int c_left = 100, p_left = 22;
    for (int i = 0; i < cycles; i++) begin
      wait_slot(1);
      if (--c_left <= 0) begin
        cpu_stop_n = ~cpu_stop_n;
        c_left = cpu_stop_n ? 100 + int'($urandom % 40) : 1 + int'($urandom % 40);
      end
      if (--p_left <= 0) begin
        pci_stop_n = ~pci_stop_n;
        p_left = pci_stop_n ? 22 + int'($urandom % 30) : 1 + int'($urandom % 30);
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge cpu_clk);
    n_fail++;
    $display("FAIL watchdog (R1..) : actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);

    // directed: processor stop while bus runs (R5, R6, R11)
    wait_slot(120);
    cpu_stop_n = 1'b0;
    wait_slot(6);
    @(posedge pci_clk); #1;
    chk(&pci_clk_o, "R11", pci_clk_o, all_bits(PCI_N, 1'b1));
    wait_slot(20);
    cpu_stop_n = 1'b1;
    wait_slot(110);

    // directed: bus stop while processor runs (R7, R8, R11)
    pci_stop_n = 1'b0;
    wait_slot(8);
    @(posedge cpu_clk); #1;
    chk(&cpu_clk_o, "R11", cpu_clk_o, all_bits(CPU_N, 1'b1));
    wait_slot(30);
    pci_stop_n = 1'b1;
    wait_slot(30);

    // directed: one-cycle stop pulse, a corner of the synchronizer (R2)
    pci_stop_n = 1'b0;
    wait_slot(1);
    pci_stop_n = 1'b1;
    wait_slot(30);

    random_run(3000);

    // desktop mode: requests ignored (R9)
    do_reset(1'b0);
    random_run(1000);
    wait_slot(4);
    finish_run();
  end
endmodule